// File: doc/BRIEF.md
# Burst-Mode Packet Transmit Assembler

This block sits between a slow host and a fast serial transmitter. While the chip-enable input is high, the host shifts address and payload bits in one at a time with its own strobe, at whatever rate suits it. Each accepted bit is stored in an internal buffer and folded into a running checksum as it arrives.

When chip enable drops, the block builds a frame and sends it one bit per bit-rate tick. The frame is an alternating training pattern, then the stored bits in load order, then an optional 8- or 16-bit checksum. Because the tick is a separate input, the same logic serves any on-air rate. Once the last bit has been on the line for a full bit period, the block flags completion and returns to standby.

Top module: `burst_tx_asm`

## Requirements
- R1: While rst_ni is low, and at the first sample after reset, tx_data_o, tx_active_o, done_o and overflow_o are all 0.
- R2: While ce_i is high, each rising edge of host_clk_i (sampled in the clk_i domain) stores host_data_i as the next bit. The first stored bit is the first address bit. Stored bits keep their arrival order.
- R3: In the cycle after ce_i falls (block idle or loading), tx_active_o goes high. It stays high until the frame completes.
- R4: The frame opens with 8 training bits. The first training bit equals the first stored bit (0 if no bit was stored), and each following bit is the inverse of the one before it. A first bit of 0 gives 01010101 and a first bit of 1 gives 10101010, in send order.
- R5: After the training bits, the stored bits go out in the order they were loaded.
- R6: With crc_en_i=0, no checksum is sent. With crc_en_i=1 and crc_long_i=0, an 8-bit checksum follows: polynomial x^8+x^2+x+1 (0x07), preset 0xFF. With crc_long_i=1, a 16-bit checksum follows: polynomial x^16+x^12+x^5+1 (0x1021), preset 0xFFFF. Either checksum covers all stored bits, MSB first, and is sent MSB first.
- R7: The buffer holds at most 256 minus the checksum length (0, 8 or 16) bits. Host bits beyond that limit are dropped and set overflow_o. overflow_o stays set until the next rising edge of ce_i.
- R8: tx_data_o changes only at a clock edge where bit_tick_i is high. Between ticks it holds its value.
- R9: A frame of N bits takes N+1 ticks. The tick after the last bit pulses done_o for exactly one cycle, drops tx_active_o, and returns tx_data_o to 0. tx_data_o stays 0 while the block is not sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable: high loads, falling edge sends |
| host_clk_i | input | 1 | Host bit strobe; a rising edge stores a bit |
| host_data_i | input | 1 | Host serial data |
| bit_tick_i | input | 1 | One-cycle pulse per on-air bit period |
| crc_en_i | input | 1 | Append a checksum |
| crc_long_i | input | 1 | 0: 8-bit checksum, 1: 16-bit checksum |
| tx_data_o | output | 1 | Serial frame output |
| tx_active_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse when the frame is complete |
| overflow_o | output | 1 | Host loaded more bits than fit |

## Verification
Each host strobe is stored at the first clock edge that sees it high, so overflow_o is read two cycles after the last strobe. tx_active_o is sampled on the falling clock edge one full cycle after ce_i drops. Every frame bit appears at the clock edge that sees its tick, so the bench raises the tick for one cycle and reads tx_data_o at the next falling edge. It also idles two cycles between ticks to confirm the output holds. done_o is expected at the falling edge just after the (N+1)th tick, and is expected low one cycle later.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SEND} tx_state_e;

  function automatic logic [15:0] crc16_next(logic [15:0] c, logic b);
    logic fb;
    fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [7:0] crc8_next(logic [7:0] c, logic b);
    logic fb;
    fb = b ^ c[7];
    return {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
  endfunction
endpackage

// File: rtl/burst_host_loader.sv
module burst_host_loader #(
  parameter int MAX_BITS = 256,
  parameter int CNT_W    = $clog2(MAX_BITS + 1),
  parameter int BUF_IW   = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                load_en_i,
  input  logic                host_clk_i,
  input  logic                host_data_i,
  input  logic [CNT_W-1:0]    cap_i,
  output logic [MAX_BITS-1:0] buf_o,
  output logic [CNT_W-1:0]    count_o,
  output logic                wr_o,
  output logic                ovf_o
);
  logic hclk_q;
  logic rise;
  logic fits;

  assign rise = host_clk_i & ~hclk_q;
  assign fits = count_o < cap_i;
  assign wr_o = load_en_i & rise & fits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hclk_q  <= 1'b0;
      buf_o   <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      hclk_q <= host_clk_i;
      if (clear_i) begin
        count_o <= '0;
        ovf_o   <= 1'b0;
      end else if (wr_o) begin
        buf_o[count_o[BUF_IW-1:0]] <= host_data_i;
        count_o <= count_o + 1'b1;
      end else if (load_en_i && rise) begin
        ovf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_crc_unit.sv
module burst_crc_unit
  import burst_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        wr_i,
  input  logic        bit_i,
  output logic [15:0] crc16_o,
  output logic [7:0]  crc8_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc16_o <= '1;
      crc8_o  <= '1;
    end else if (clear_i) begin
      crc16_o <= '1;
      crc8_o  <= '1;
    end else if (wr_i) begin
      crc16_o <= crc16_next(crc16_o, bit_i);
      crc8_o  <= crc8_next(crc8_o, bit_i);
    end
  end
endmodule

// File: rtl/burst_frame_ser.sv
module burst_frame_ser
  import burst_tx_pkg::*;
#(
  parameter int MAX_BITS = 256,
  parameter int PRE_LEN  = 8,
  parameter int CNT_W    = $clog2(MAX_BITS + 1),
  parameter int BUF_IW   = $clog2(MAX_BITS),
  parameter int FRAME_W  = $clog2(PRE_LEN + MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_i,
  input  logic                tick_i,
  input  logic [MAX_BITS-1:0] buf_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic [4:0]          crc_len_i,
  input  logic                crc_long_i,
  input  logic [15:0]         crc16_i,
  input  logic [7:0]          crc8_i,
  output logic                clear_o,
  output logic                load_en_o,
  output logic                tx_data_o,
  output logic                tx_active_o,
  output logic                done_o
);
  tx_state_e            state_q;
  logic [FRAME_W-1:0]   idx_q, tot_q, rel, crc_j;
  logic                 first_bit, bit_nxt;

  assign clear_o     = (state_q == ST_IDLE) && ce_i;
  assign load_en_o   = (state_q == ST_LOAD) && ce_i;
  assign tx_active_o = (state_q == ST_SEND);

  assign first_bit = (count_i != '0) && buf_i[0];
  assign rel       = idx_q - FRAME_W'(PRE_LEN);
  assign crc_j     = rel - FRAME_W'(count_i);

  always_comb begin
    if (idx_q < FRAME_W'(PRE_LEN))
      bit_nxt = first_bit ^ idx_q[0];
    else if (rel < FRAME_W'(count_i))
      bit_nxt = buf_i[rel[BUF_IW-1:0]];
    else if (crc_long_i)
      bit_nxt = crc16_i[4'd15 - crc_j[3:0]];
    else
      bit_nxt = crc8_i[3'd7 - crc_j[2:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      tot_q     <= '0;
      tx_data_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          tx_data_o <= 1'b0;
          if (ce_i) state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          if (!ce_i) begin
            state_q <= ST_SEND;
            idx_q   <= '0;
            tot_q   <= FRAME_W'(PRE_LEN) + FRAME_W'(count_i) + FRAME_W'(crc_len_i);
          end
        end
        ST_SEND: begin
          if (tick_i) begin
            if (idx_q == tot_q) begin
              state_q   <= ST_IDLE;
              done_o    <= 1'b1;
              tx_data_o <= 1'b0;
            end else begin
              tx_data_o <= bit_nxt;
              idx_q     <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_tx_asm.sv
module burst_tx_asm #(
  parameter int MAX_BITS = 256,
  parameter int PRE_LEN  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic host_clk_i,
  input  logic host_data_i,
  input  logic bit_tick_i,
  input  logic crc_en_i,
  input  logic crc_long_i,
  output logic tx_data_o,
  output logic tx_active_o,
  output logic done_o,
  output logic overflow_o
);
  localparam int CNT_W  = $clog2(MAX_BITS + 1);
  localparam int BUF_IW = $clog2(MAX_BITS);

  logic [MAX_BITS-1:0] buf_w;
  logic [CNT_W-1:0]    count_w, cap_w;
  logic [4:0]          crc_len;
  logic [15:0]         crc16_w;
  logic [7:0]          crc8_w;
  logic                clear_w, load_en_w, wr_w;

  assign crc_len = !crc_en_i ? 5'd0 : (crc_long_i ? 5'd16 : 5'd8);
  assign cap_w   = CNT_W'(MAX_BITS) - CNT_W'(crc_len);

  burst_host_loader #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .BUF_IW(BUF_IW)) u_loader (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_w), .load_en_i(load_en_w),
    .host_clk_i(host_clk_i), .host_data_i(host_data_i), .cap_i(cap_w),
    .buf_o(buf_w), .count_o(count_w), .wr_o(wr_w), .ovf_o(overflow_o)
  );

  burst_crc_unit u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_w), .wr_i(wr_w),
    .bit_i(host_data_i), .crc16_o(crc16_w), .crc8_o(crc8_w)
  );

  burst_frame_ser #(.MAX_BITS(MAX_BITS), .PRE_LEN(PRE_LEN)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .tick_i(bit_tick_i),
    .buf_i(buf_w), .count_i(count_w), .crc_len_i(crc_len), .crc_long_i(crc_long_i),
    .crc16_i(crc16_w), .crc8_i(crc8_w), .clear_o(clear_w), .load_en_o(load_en_w),
    .tx_data_o(tx_data_o), .tx_active_o(tx_active_o), .done_o(done_o)
  );
endmodule

// File: rtl/burst_tx_asm_chk.sv
module burst_tx_asm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_i,
  input logic bit_tick_i,
  input logic tx_data_o,
  input logic tx_active_o,
  input logic done_o,
  input logic overflow_o
);
  AST_SEND_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ce_i) && !tx_active_o && !done_o) |=> tx_active_o); // R3

  AST_OVF_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(ce_i)); // R7

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_active_o && !bit_tick_i) |=> $stable(tx_data_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_active_o); // R9

  AST_QUIET_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_o |-> !tx_data_o); // R9
endmodule

bind burst_tx_asm burst_tx_asm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .bit_tick_i(bit_tick_i),
  .tx_data_o(tx_data_o), .tx_active_o(tx_active_o), .done_o(done_o),
  .overflow_o(overflow_o)
);

// File: tb/burst_tx_asm_test.sv
module burst_tx_asm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, hclk = 1'b0, hdat = 1'b0, tick = 1'b0;
  logic crc_en = 1'b0, crc_long = 1'b0;
  logic tx_data, tx_active, done, ovf;
  int   checks = 0, errors = 0;
  logic [0:299] exp_bits;
  logic [0:255] ld_bits;

  always #2.5 clk = ~clk;

  burst_tx_asm uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .host_clk_i(hclk), .host_data_i(hdat),
    .bit_tick_i(tick), .crc_en_i(crc_en), .crc_long_i(crc_long),
    .tx_data_o(tx_data), .tx_active_o(tx_active), .done_o(done), .overflow_o(ovf)
  );

  // {crc_en, crc_long, exp_ovf, n_load[8:0], pattern[31:0]}
  localparam logic [43:0] VEC [5] = '{
    {1'b0, 1'b0, 1'b0, 9'd16,  32'hA5C30F0F},
    {1'b1, 1'b0, 1'b0, 9'd24,  32'h12345678},
    {1'b1, 1'b1, 1'b0, 9'd40,  32'hF00DBEEF},
    {1'b1, 1'b1, 1'b0, 9'd240, 32'hDEADBEEF},
    {1'b1, 1'b0, 1'b1, 9'd250, 32'h3C3C5AA5}
  };

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic host_bit(logic b);
    @(negedge clk) begin hdat = b; hclk = 1'b1; end
    @(negedge clk) hclk = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic run_frame(logic en, logic lng, int n, logic [31:0] pat, logic exp_ovf);
    int cap, kept, clen, nbits;
    logic [15:0] c16;
    logic [7:0]  c8;
    logic first, prev;
    crc_en = en; crc_long = lng;
    clen = !en ? 0 : (lng ? 16 : 8);
    cap  = 256 - clen;
    kept = (n < cap) ? n : cap;
    c16 = 16'hFFFF; c8 = 8'hFF;
    @(negedge clk) ce = 1'b1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = pat[31 - (i % 32)];
      host_bit(b);
      if (i < kept) begin
        ld_bits[i] = b;
        c16 = {c16[14:0], 1'b0} ^ ((b ^ c16[15]) ? 16'h1021 : 16'h0);
        c8  = {c8[6:0], 1'b0} ^ ((b ^ c8[7]) ? 8'h07 : 8'h0);
      end
    end
    @(negedge clk);
    check("R7 overflow flag", ovf, exp_ovf);
    first = (kept > 0) ? ld_bits[0] : 1'b0;
    nbits = 8 + kept + clen;
    for (int k = 0; k < 8; k++) exp_bits[k] = first ^ k[0];
    for (int k = 0; k < kept; k++) exp_bits[8 + k] = ld_bits[k];
    for (int k = 0; k < clen; k++)
      exp_bits[8 + kept + k] = lng ? c16[15 - k] : c8[7 - k];
    ce = 1'b0;
    @(negedge clk);
    check("R3 active after ce fall", tx_active, 1'b1);
    prev = tx_data;
    for (int k = 0; k < nbits; k++) begin
      repeat (2) @(negedge clk);
      check("R8 hold between ticks", tx_data, prev);
      pulse_tick();
      if (k < 8) check("R4 training bit", tx_data, exp_bits[k]);
      else if (k < 8 + kept) check("R5 stored bit", tx_data, exp_bits[k]);
      else check("R6 checksum bit", tx_data, exp_bits[k]);
      check("R3 active during frame", tx_active, 1'b1);
      prev = tx_data;
    end
    pulse_tick();
    check("R9 done pulse", done, 1'b1);
    check("R9 active low at end", tx_active, 1'b0);
    check("R9 line low at end", tx_data, 1'b0);
    @(negedge clk);
    check("R9 done one cycle", done, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset tx_data", tx_data, 1'b0);
    check("R1 reset active", tx_active, 1'b0);
    check("R1 reset done", done, 1'b0);
    check("R1 reset overflow", ovf, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset tx_data", tx_data, 1'b0);
    check("R1 after reset active", tx_active, 1'b0);
    // R2 R4 R5 R6 R7 from the vector table
    for (int v = 0; v < 5; v++)
      run_frame(VEC[v][43], VEC[v][42], int'(VEC[v][40:32]), VEC[v][31:0], VEC[v][41]);
    // R7 overflow clears on next ce rise; R4 empty load uses first bit 0
    run_frame(1'b0, 1'b0, 0, 32'h0, 1'b0);
    // R6 empty 16-bit checksum is the preset
    run_frame(1'b1, 1'b1, 0, 32'h0, 1'b0);
    // R2 strobes with ce low are not stored: next frame carries only its own bits
    repeat (3) host_bit(1'b1);
    run_frame(1'b1, 1'b0, 8, 32'h5A000000, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule